// File: doc/BRIEF.md
# Serial EEPROM configuration autoloader

After reset this block fetches a fixed 18-word (36-byte) configuration image from a serial EEPROM. Each word is fetched by its own read transaction. The block drives chip select, a divided-down serial clock and a command line, and it samples the returned data line. The sixteen data bits of each word arrive most significant bit first.

While the words arrive, the block adds every byte into an 8-bit running total, with carries discarded. Each word is also copied into shadow storage:
- words 0 to 2 go to the six-byte station address;
- eight further words go to configuration register slots.

Once the last word has arrived, the total is compared with FFh.
- If it matches, the shadow contents are committed to the outputs in one step.
- If it does not match, the outputs keep their previous contents and an error flag is raised.

In both cases a one-cycle done pulse marks the end of the load. A restart input starts a fresh load once the block is idle.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: Each word read is one transaction. Chip select goes high, then 9 command bits are sent on `ee_di`: start bit 1, opcode `10`, then the 6-bit word address MSB first. Then 16 data bits are taken from `ee_do`. Every bit is taken at a rising edge of `ee_sk`. Chip select goes low after the 16th data bit.
- R2: A load makes exactly 18 transactions, at word addresses 0 to 17 in ascending order.
- R3: The first data bit of a word becomes bit 15 of the stored word, and the last becomes bit 0.
- R4: Word j holds EEPROM byte 2j in bits 7:0 and byte 2j+1 in bits 15:8. `node_addr` bits 8k+7:8k hold EEPROM byte k, for k = 0 to 5, so `node_addr` = {word2, word1, word0}.
- R5: Configuration slot k is `cfg_regs` bits 16k+15:16k. Slots 0 to 6 receive words 08h to 0Eh in order, and slot 7 receives word 10h. The other words reach no slot.
- R6: When the 8-bit sum of all 36 bytes equals FFh, `node_addr` and `cfg_regs` take the new image in the cycle where `load_done` is high, and `cksum_err` stays 0. At no other time do these outputs change.
- R7: When the sum differs from FFh, `node_addr` and `cfg_regs` keep their previous values, and `cksum_err` rises together with `load_done`. A change in any single byte of the image produces this outcome.
- R8: `load_done` is high for exactly one cycle per load, after the 18th word. A restart accepted while idle clears `cksum_err` in the next cycle.
- R9: `ee_sk` stays high and stays low for HALF_DIV clock cycles in each bit. `ee_sk` is low whenever `ee_cs` is low.
- R10: A `restart` pulse while a load is running has no effect: the load still makes 18 transactions and ends with a single `load_done`.
- R11: During reset and after it, until the first commit, `node_addr` and `cfg_regs` are 0, and `load_done` and `cksum_err` are 0. The first load starts without any restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| restart | input | 1 | Starts a new load when idle |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Command bits to the EEPROM |
| ee_do | input | 1 | Data bits from the EEPROM |
| node_addr | output | 48 | Committed six-byte station address |
| cfg_regs | output | 128 | Committed configuration slots, 16 bits each |
| load_done | output | 1 | One-cycle pulse at the end of a load |
| cksum_err | output | 1 | Last load failed its byte-sum check |

## Verification
The bench uses a behavioural EEPROM model. It sweeps a single-byte corruption over all 36 byte positions, including the adjust byte and word 11h, which feed the sum but no output. A design that summed only the mapped words, or dropped the carry wrongly, would commit a corrupt image on some of these positions. A word whose bit pattern is not a palindrome shows a reversed shift order as a wrong slot value. A restart pulsed mid-load shows a design that re-arms while busy, because it makes extra transactions or extra done pulses. The frame log catches addresses that are skipped or issued out of order.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
    localparam int WORDS      = 18;
    localparam int WIDX_W     = $clog2(WORDS);
    localparam int WORD_W     = 16;
    localparam int NODE_WORDS = 3;
    localparam int CFG_SLOTS  = 8;
    localparam int SLOT_W     = $clog2(CFG_SLOTS);
    localparam int SUM_TARGET = 8'hFF;

    // word index -> configuration slot
    function automatic logic slot_valid(input logic [WIDX_W-1:0] w);
        return (w >= WIDX_W'(8) && w <= WIDX_W'(14)) || w == WIDX_W'(16);
    endfunction

    function automatic logic [SLOT_W-1:0] slot_index(input logic [WIDX_W-1:0] w);
        return (w == WIDX_W'(16)) ? SLOT_W'(7) : SLOT_W'(w - WIDX_W'(8));
    endfunction
endpackage

// File: rtl/ee_serial_engine.sv
module ee_serial_engine #(
    parameter int HALF_DIV = 4,
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    output logic              done,
    output logic [DATA_W-1:0] word,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do
);
    localparam int CMD_W = 3 + ADDR_W;
    localparam int FRAME = CMD_W + DATA_W;
    localparam int BIT_W = $clog2(FRAME + 1);
    localparam int CNT_W = $clog2(2 * HALF_DIV + 1);

    typedef enum logic [1:0] {E_IDLE, E_LOW, E_HIGH, E_GAP} phase_t;

    typedef struct packed {
        phase_t            phase;
        logic [CNT_W-1:0]  cnt;
        logic [BIT_W-1:0]  bitn;
        logic [CMD_W-1:0]  cmd;
        logic [DATA_W-1:0] data;
        logic              sk;
        logic              cs;
        logic              di;
        logic              done;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.phase)
            E_IDLE: begin
                if (start) begin
                    d.cs    = 1'b1;
                    d.sk    = 1'b0;
                    d.cmd   = {3'b110, addr};
                    d.di    = 1'b1;
                    d.bitn  = '0;
                    d.cnt   = '0;
                    d.phase = E_LOW;
                end
            end
            E_LOW: begin
                if (q.cnt == CNT_W'(HALF_DIV - 1)) begin
                    d.cnt   = '0;
                    d.sk    = 1'b1;
                    d.phase = E_HIGH;
                    if (q.bitn >= BIT_W'(CMD_W))
                        d.data = {q.data[DATA_W-2:0], ee_do};
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            E_HIGH: begin
                if (q.cnt == CNT_W'(HALF_DIV - 1)) begin
                    d.cnt = '0;
                    d.sk  = 1'b0;
                    if (q.bitn == BIT_W'(FRAME - 1)) begin
                        d.phase = E_GAP;
                        d.cs    = 1'b0;
                        d.di    = 1'b0;
                    end else begin
                        d.bitn  = q.bitn + 1'b1;
                        d.cmd   = {q.cmd[CMD_W-2:0], 1'b0};
                        d.di    = q.cmd[CMD_W-2];
                        d.phase = E_LOW;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: begin
                if (q.cnt == CNT_W'(2 * HALF_DIV - 1)) begin
                    d.cnt   = '0;
                    d.phase = E_IDLE;
                    d.done  = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: E_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign done  = q.done;
    assign word  = q.data;
    assign ee_cs = q.cs;
    assign ee_sk = q.sk;
    assign ee_di = q.di;
endmodule

// File: rtl/cfg_load_seq.sv
module cfg_load_seq
    import cfg_loader_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               restart,
    output logic                               eng_start,
    output logic [ADDR_W-1:0]                  eng_addr,
    input  logic                               eng_done,
    input  logic [WORD_W-1:0]                  eng_word,
    output logic [NODE_WORDS-1:0][WORD_W-1:0]  node,
    output logic [CFG_SLOTS-1:0][WORD_W-1:0]   cfg,
    output logic                               load_done,
    output logic                               cksum_err
);
    typedef enum logic [1:0] {S_ISSUE, S_WAIT, S_IDLE} seq_phase_t;

    typedef struct packed {
        seq_phase_t                       phase;
        logic [WIDX_W-1:0]                widx;
        logic [7:0]                       sum;
        logic [NODE_WORDS-1:0][WORD_W-1:0] sh_node;
        logic [CFG_SLOTS-1:0][WORD_W-1:0]  sh_cfg;
        logic [NODE_WORDS-1:0][WORD_W-1:0] node;
        logic [CFG_SLOTS-1:0][WORD_W-1:0]  cfg;
        logic                             done;
        logic                             err;
    } seq_t;

    seq_t       q, d;
    logic [7:0] sum_new;

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        eng_start = 1'b0;
        sum_new   = q.sum + eng_word[7:0] + eng_word[15:8];
        case (q.phase)
            S_ISSUE: begin
                eng_start = 1'b1;
                d.phase   = S_WAIT;
            end
            S_WAIT: begin
                if (eng_done) begin
                    d.sum = sum_new;
                    if (q.widx < WIDX_W'(NODE_WORDS))
                        d.sh_node[q.widx[1:0]] = eng_word;
                    if (slot_valid(q.widx))
                        d.sh_cfg[slot_index(q.widx)] = eng_word;
                    if (q.widx == WIDX_W'(WORDS - 1)) begin
                        d.phase = S_IDLE;
                        d.done  = 1'b1;
                        if (sum_new == 8'(SUM_TARGET)) begin
                            d.node = d.sh_node;
                            d.cfg  = d.sh_cfg;
                        end else begin
                            d.err = 1'b1;
                        end
                    end else begin
                        d.widx  = q.widx + 1'b1;
                        d.phase = S_ISSUE;
                    end
                end
            end
            default: begin
                if (restart) begin
                    d.widx  = '0;
                    d.sum   = '0;
                    d.err   = 1'b0;
                    d.phase = S_ISSUE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: S_ISSUE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign eng_addr  = ADDR_W'(q.widx);
    assign node      = q.node;
    assign cfg       = q.cfg;
    assign load_done = q.done;
    assign cksum_err = q.err;
endmodule

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int HALF_DIV = 4,
    parameter int ADDR_W   = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          restart,
    output logic                          ee_cs,
    output logic                          ee_sk,
    output logic                          ee_di,
    input  logic                          ee_do,
    output logic [NODE_WORDS*WORD_W-1:0]  node_addr,
    output logic [CFG_SLOTS*WORD_W-1:0]   cfg_regs,
    output logic                          load_done,
    output logic                          cksum_err
);
    logic                              eng_start;
    logic                              eng_done;
    logic [ADDR_W-1:0]                 eng_addr;
    logic [WORD_W-1:0]                 eng_word;
    logic [NODE_WORDS-1:0][WORD_W-1:0] node_w;
    logic [CFG_SLOTS-1:0][WORD_W-1:0]  cfg_w;

    ee_serial_engine #(
        .HALF_DIV (HALF_DIV),
        .ADDR_W   (ADDR_W),
        .DATA_W   (WORD_W)
    ) i_engine (
        .clk   (clk),
        .rst_n (rst_n),
        .start (eng_start),
        .addr  (eng_addr),
        .done  (eng_done),
        .word  (eng_word),
        .ee_cs (ee_cs),
        .ee_sk (ee_sk),
        .ee_di (ee_di),
        .ee_do (ee_do)
    );

    cfg_load_seq #(
        .ADDR_W (ADDR_W)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .eng_start (eng_start),
        .eng_addr  (eng_addr),
        .eng_done  (eng_done),
        .eng_word  (eng_word),
        .node      (node_w),
        .cfg       (cfg_w),
        .load_done (load_done),
        .cksum_err (cksum_err)
    );

    assign node_addr = node_w;
    assign cfg_regs  = cfg_w;
endmodule

// File: rtl/cfg_loader_checker.sv
module cfg_loader_checker #(
    parameter int HALF_DIV = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         restart,
    input logic         ee_cs,
    input logic         ee_sk,
    input logic [47:0]  node_addr,
    input logic [127:0] cfg_regs,
    input logic         load_done,
    input logic         cksum_err
);
    logic        sk_prev;
    logic [15:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sk_prev <= 1'b0;
            run_cnt <= '0;
        end else begin
            sk_prev <= ee_sk;
            if (ee_sk != sk_prev)
                run_cnt <= '0;
            else if (run_cnt != 16'hFFFF)
                run_cnt <= run_cnt + 1'b1;
        end
    end

    assert_sk_low_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_cs |-> !ee_sk);

    assert_sk_high_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sk_prev && !ee_sk) |-> run_cnt == 16'(HALF_DIV - 1));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> !load_done);

    assert_err_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cksum_err) |-> $past(restart));

    assert_commit_at_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cfg_regs) || !$stable(node_addr)) |-> load_done);

    assert_err_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cksum_err) |-> load_done);

    assert_keep_on_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_done && cksum_err) |-> ($stable(cfg_regs) && $stable(node_addr)));
endmodule

bind eeprom_cfg_loader cfg_loader_checker #(.HALF_DIV(HALF_DIV)) i_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .ee_cs     (ee_cs),
    .ee_sk     (ee_sk),
    .node_addr (node_addr),
    .cfg_regs  (cfg_regs),
    .load_done (load_done),
    .cksum_err (cksum_err)
);

// File: tb/test_eeprom_cfg_loader.sv
`timescale 1ns/1ps
module test_eeprom_cfg_loader;
    localparam int HALF = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         restart = 1'b0;
    logic         ee_cs, ee_sk, ee_di;
    logic         ee_do = 1'b0;
    logic [47:0]  node_addr;
    logic [127:0] cfg_regs;
    logic         load_done, cksum_err;

    always #2.5 clk = ~clk;

    eeprom_cfg_loader #(.HALF_DIV(HALF)) i_eeprom_cfg_loader (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do),
        .node_addr(node_addr), .cfg_regs(cfg_regs),
        .load_done(load_done), .cksum_err(cksum_err)
    );

    int nchk = 0;
    int nerr = 0;

    // behavioural EEPROM
    logic [15:0] mem [0:63];
    logic [8:0]  flog [0:63];
    logic [8:0]  cmd = '0;
    int          nbits = 0;
    int          nfr = 0;

    always @(posedge ee_sk or negedge ee_cs) begin
        if (!ee_cs) begin
            if (nbits > 0 && nfr < 64) begin
                flog[nfr] = cmd;
                nfr++;
            end
            nbits = 0;
        end else begin
            if (nbits < 9) cmd = {cmd[7:0], ee_di};
            nbits++;
        end
    end

    always @(negedge ee_sk) begin
        if (ee_cs && nbits >= 9 && nbits < 25)
            ee_do = mem[cmd[5:0]][24-nbits];
    end

    // port monitors
    int hi_run = 0, hi_min = 1000, hi_max = 0, idle_bad = 0, ndone = 0;
    always @(negedge clk) begin
        if (ee_sk) hi_run++;
        else if (hi_run != 0) begin
            if (hi_run < hi_min) hi_min = hi_run;
            if (hi_run > hi_max) hi_max = hi_run;
            hi_run = 0;
        end
        if (!ee_cs && ee_sk) idle_bad++;
        if (load_done) ndone++;
    end

    logic [47:0]  cur_node = '0;
    logic [127:0] cur_cfg  = '0;

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] image_sum();
        logic [7:0] s = 8'h00;
        for (int w = 0; w < 18; w++) s = s + mem[w][7:0] + mem[w][15:8];
        return s;
    endfunction

    task automatic fix_adjust();
        mem[15][15:8] = 8'h00;
        mem[15][15:8] = 8'hFF - image_sum();
    endtask

    task automatic make_image(input int seed);
        for (int w = 0; w < 64; w++) mem[w] = 16'hFFFF;
        for (int w = 0; w < 18; w++)
            mem[w] = 16'((seed * 16'h1357) + (w * 16'h0B3D)) ^ 16'(w << 9);
        fix_adjust();
    endtask

    function automatic logic [127:0] exp_cfg();
        logic [127:0] v;
        for (int k = 0; k < 8; k++) v[16*k +: 16] = (k < 7) ? mem[8+k] : mem[16];
        return v;
    endfunction

    task automatic wait_done(input string req);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!load_done && n < 20000);
        chk({req, " load_done seen"}, 128'(load_done), 128'd1);
    endtask

    task automatic pulse_restart();
        @(negedge clk);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
    endtask

    task automatic check_frames();
        chk("R2 frame count", 128'(nfr), 128'd18);
        for (int i = 0; i < nfr && i < 18; i++) begin
            chk("R1 start+opcode", 128'(flog[i][8:6]), 128'(3'b110));
            chk("R2 address order", 128'(flog[i][5:0]), 128'(i));
        end
    endtask

    task automatic check_good();
        chk("R6 no error", 128'(cksum_err), 128'd0);
        chk("R4 node address", 128'(node_addr), 128'({mem[2], mem[1], mem[0]}));
        for (int k = 0; k < 8; k++)
            chk("R5 slot value", 128'(cfg_regs[16*k +: 16]), 128'(exp_cfg()[16*k +: 16]));
        cur_node = node_addr;
        cur_cfg  = cfg_regs;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        make_image(1);
        repeat (4) @(negedge clk);
        // R11 reset state
        chk("R11 done in reset", 128'(load_done), 128'd0);
        chk("R11 err in reset", 128'(cksum_err), 128'd0);
        chk("R11 node in reset", 128'(node_addr), 128'd0);
        chk("R11 cfg in reset", cfg_regs, 128'd0);
        chk("R11 cs in reset", 128'(ee_cs), 128'd0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk("R11 auto start cs", 128'(ee_cs), 128'd1);
        chk("R11 cfg before commit", cfg_regs, 128'd0);

        wait_done("R6 first load");
        check_good();
        @(negedge clk);
        check_frames();
        chk("R9 sk high min", 128'(hi_min), 128'(HALF));
        chk("R9 sk high max", 128'(hi_max), 128'(HALF));
        chk("R9 sk low when cs low", 128'(idle_bad), 128'd0);

        // R10: restart during a running load
        make_image(2);
        nfr = 0;
        pulse_restart();
        repeat (300) @(negedge clk);
        pulse_restart();
        repeat (500) @(negedge clk);
        pulse_restart();
        ndone = 0;
        wait_done("R10 load");
        check_good();
        repeat (3000) @(negedge clk);
        chk("R10 frames", 128'(nfr), 128'd18);
        chk("R10 single done", 128'(ndone), 128'd1);
        check_frames();

        // R7: one corrupted byte at every position
        for (int p = 0; p < 36; p++) begin
            make_image(2);
            if (p[0]) mem[p/2][15:8] = mem[p/2][15:8] ^ 8'h5A;
            else      mem[p/2][7:0]  = mem[p/2][7:0]  ^ 8'h5A;
            pulse_restart();
            @(negedge clk);
            chk("R8 err cleared on restart", 128'(cksum_err), 128'd0);
            wait_done("R7 corrupt load");
            chk("R7 err set", 128'(cksum_err), 128'd1);
            chk("R7 node kept", 128'(node_addr), 128'(cur_node));
            chk("R7 cfg kept", cfg_regs, cur_cfg);
            @(negedge clk);
            chk("R8 done one cycle", 128'(load_done), 128'd0);
        end

        // R3: bit order with non-palindromic words
        make_image(3);
        mem[8] = 16'hC001;
        mem[0] = 16'h8E01;
        fix_adjust();
        pulse_restart();
        @(negedge clk);
        chk("R8 err cleared after failure", 128'(cksum_err), 128'd0);
        wait_done("R3 load");
        check_good();
        chk("R3 slot0 msb first", 128'(cfg_regs[15:0]), 128'(16'hC001));
        chk("R3 node byte0", 128'(node_addr[7:0]), 128'(8'h01));
        chk("R3 node byte1", 128'(node_addr[15:8]), 128'(8'h8E));

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule